// File: doc/BRIEF.md
# Round-Robin Arbiter for Shared AXI-Lite Slave

This block lets several AXI-Lite masters share a single AXI-Lite slave. It grants the slave to one master at a time. While a master holds the grant, its address, write data and response channels, or its read address and read data channels, are connected straight through to the slave. The grant is kept until the response handshake of that one transaction completes. Write and read requests compete at the same arbitration point, so the slave never has more than one transaction outstanding.

Masters are served in round-robin order. When a transaction ends, the round-robin pointer moves to the master after the one that just finished. There is one exception: a master that presents a new request in the very next cycle keeps the slave. A master that streams transactions back to back therefore finishes its whole burst before another master is served. Masters that pause for at least one cycle between transactions take turns with the others.

The master count, address width and data width are parameters. Per-master signals are packed side by side into flat vectors, with master i in slice i.

Top module: `axil_rr_arbiter`

## Requirements
- R1: After reset no master is granted. Every master sees its address-ready, write-ready, read-ready, response-valid and read-valid outputs low, and the slave-side address and write valids are low until a request arrives. The round-robin pointer starts at master 0, so if all masters request in the same cycle after reset, master 0 is served first.
- R2: The winner is the first requesting master at or after the pointer, wrapping from NUM_M-1 to 0. On release the pointer becomes the finished master's index plus one, modulo NUM_M. Every accepted request eventually reaches the slave.
- R3: A master whose next request (AWVALID or ARVALID high) is present in the cycle right after its response handshake keeps the grant. With three masters each issuing back-to-back traffic, the slave sees all of master 0's transactions, then all of master 1's, then all of master 2's.
- R4: When each master leaves at least one idle cycle between transactions, the grant rotates after every transaction, and the slave sees masters in the order 0, 1, 2, 0, 1, 2 and so on.
- R5: Read transactions follow the same grant, hold and rotation rules as writes, and show the same orderings.
- R6: When a master raises a write request (AWVALID) and a read request (ARVALID) in the same cycle, the write is served first and the read follows.
- R7: In every cycle, at most one master sees any of its AWREADY, WREADY, ARREADY, BVALID or RVALID outputs high.
- R8: At most one transaction is outstanding on the slave. No new write or read address handshake occurs before the current transaction's B or R handshake.
- R9: The following pass through unchanged: address, protection bits, write data and strobes from the owner to the slave, and the response code (2-bit: 00 OKAY, 10 SLVERR, 11 DECERR) and read data from the slave to the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_awvalid | input | NUM_M | Write address valid per master |
| m_awready | output | NUM_M | Write address ready per master |
| m_awaddr | input | NUM_M*ADDR_W | Write addresses, master i in slice i |
| m_awprot | input | NUM_M*3 | Write protection bits |
| m_wvalid | input | NUM_M | Write data valid |
| m_wready | output | NUM_M | Write data ready |
| m_wdata | input | NUM_M*DATA_W | Write data |
| m_wstrb | input | NUM_M*DATA_W/8 | Write byte strobes |
| m_bvalid | output | NUM_M | Write response valid |
| m_bready | input | NUM_M | Write response ready |
| m_bresp | output | NUM_M*2 | Write response codes |
| m_arvalid | input | NUM_M | Read address valid |
| m_arready | output | NUM_M | Read address ready |
| m_araddr | input | NUM_M*ADDR_W | Read addresses |
| m_arprot | input | NUM_M*3 | Read protection bits |
| m_rvalid | output | NUM_M | Read data valid |
| m_rready | input | NUM_M | Read data ready |
| m_rdata | output | NUM_M*DATA_W | Read data |
| m_rresp | output | NUM_M*2 | Read response codes |
| s_awvalid | output | 1 | Slave write address valid |
| s_awready | input | 1 | Slave write address ready |
| s_awaddr | output | ADDR_W | Slave write address |
| s_awprot | output | 3 | Slave write protection bits |
| s_wvalid | output | 1 | Slave write data valid |
| s_wready | input | 1 | Slave write data ready |
| s_wdata | output | DATA_W | Slave write data |
| s_wstrb | output | DATA_W/8 | Slave write strobes |
| s_bvalid | input | 1 | Slave write response valid |
| s_bready | output | 1 | Slave write response ready |
| s_bresp | input | 2 | Slave write response code |
| s_arvalid | output | 1 | Slave read address valid |
| s_arready | input | 1 | Slave read address ready |
| s_araddr | output | ADDR_W | Slave read address |
| s_arprot | output | 3 | Slave read protection bits |
| s_rvalid | input | 1 | Slave read data valid |
| s_rready | output | 1 | Slave read data ready |
| s_rdata | input | DATA_W | Slave read data |
| s_rresp | input | 2 | Slave read response code |

## Verification
The hardest situation to reach is the single cycle right after a response handshake. In that cycle the finished master's re-request must beat the pointer, and its absence must hand the slave to the next requester. The bench reaches both sides of this by having masters re-request exactly one cycle after their B or R handshake in one pass, and exactly two cycles after it in another, with all other masters kept waiting. A further directed case stalls the pointer at the last master so the search wraps. A same-cycle write and read from one master checks the write-first rule. Random delays, mixed transaction kinds and a randomly stalling slave then cover the address and write data arriving in either order.

// File: rtl/axil_arb_pkg.sv
package axil_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2
    } arb_state_e;

    localparam int PROT_W = 3;
    localparam int RESP_W = 2;

endpackage

// File: rtl/axil_rr_pick.sv
module axil_rr_pick #(
    parameter int NUM_M = 3,
    parameter int IDX_W = 2
) (
    input  logic [NUM_M-1:0] req,
    input  logic [IDX_W-1:0] ptr,
    input  logic             keep_en,
    input  logic [IDX_W-1:0] keep_idx,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    generate
        if (NUM_M == 1) begin : g_single
            assign any = req[0];
            assign idx = '0;
        end else begin : g_multi
            logic found;
            always_comb begin
                any   = |req;
                idx   = '0;
                found = 1'b0;
                // first requester at or after the pointer, wrapping
                for (int k = 0; k < NUM_M; k++) begin
                    if (!found && req[(int'(ptr) + k) % NUM_M]) begin
                        idx   = IDX_W'((int'(ptr) + k) % NUM_M);
                        found = 1'b1;
                    end
                end
                // the master that just finished wins if it re-requests at once
                if (keep_en && req[keep_idx]) begin
                    idx = keep_idx;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/axil_wr_route.sv
module axil_wr_route #(
    parameter int NUM_M  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [IDX_W-1:0]           owner,
    input  logic                       aw_done,
    input  logic                       w_done,
    input  logic [NUM_M-1:0]           m_awvalid,
    output logic [NUM_M-1:0]           m_awready,
    input  logic [NUM_M*ADDR_W-1:0]    m_awaddr,
    input  logic [NUM_M*3-1:0]         m_awprot,
    input  logic [NUM_M-1:0]           m_wvalid,
    output logic [NUM_M-1:0]           m_wready,
    input  logic [NUM_M*DATA_W-1:0]    m_wdata,
    input  logic [NUM_M*DATA_W/8-1:0]  m_wstrb,
    output logic [NUM_M-1:0]           m_bvalid,
    input  logic [NUM_M-1:0]           m_bready,
    output logic [NUM_M*2-1:0]         m_bresp,
    output logic                       s_awvalid,
    input  logic                       s_awready,
    output logic [ADDR_W-1:0]          s_awaddr,
    output logic [2:0]                 s_awprot,
    output logic                       s_wvalid,
    input  logic                       s_wready,
    output logic [DATA_W-1:0]          s_wdata,
    output logic [DATA_W/8-1:0]        s_wstrb,
    input  logic                       s_bvalid,
    output logic                       s_bready,
    input  logic [1:0]                 s_bresp,
    output logic                       aw_hs,
    output logic                       w_hs,
    output logic                       b_hs
);

    localparam int STRB_W = DATA_W / 8;

    logic [NUM_M-1:0] sel;
    logic             both_in;

    assign both_in = aw_done && w_done;

    generate
        for (genvar i = 0; i < NUM_M; i++) begin : g_m
            assign sel[i]           = en && (owner == IDX_W'(i));
            assign m_awready[i]     = sel[i] && !aw_done && s_awready;
            assign m_wready[i]      = sel[i] && !w_done && s_wready;
            assign m_bvalid[i]      = sel[i] && both_in && s_bvalid;
            assign m_bresp[i*2 +: 2] = s_bresp;
        end
    endgenerate

    always_comb begin
        s_awaddr = '0;
        s_awprot = '0;
        s_wdata  = '0;
        s_wstrb  = '0;
        for (int i = 0; i < NUM_M; i++) begin
            if (sel[i]) begin
                s_awaddr = m_awaddr[i*ADDR_W +: ADDR_W];
                s_awprot = m_awprot[i*3 +: 3];
                s_wdata  = m_wdata[i*DATA_W +: DATA_W];
                s_wstrb  = m_wstrb[i*STRB_W +: STRB_W];
            end
        end
    end

    assign s_awvalid = en && !aw_done && |(sel & m_awvalid);
    assign s_wvalid  = en && !w_done && |(sel & m_wvalid);
    assign s_bready  = en && both_in && |(sel & m_bready);

    assign aw_hs = s_awvalid && s_awready;
    assign w_hs  = s_wvalid && s_wready;
    assign b_hs  = s_bvalid && s_bready;

    // R9: a slave write response lands on exactly one master
    assert_b_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        b_hs |-> $onehot(m_bvalid & m_bready));

endmodule

// File: rtl/axil_rd_route.sv
module axil_rd_route #(
    parameter int NUM_M  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [IDX_W-1:0]        owner,
    input  logic                    ar_done,
    input  logic [NUM_M-1:0]        m_arvalid,
    output logic [NUM_M-1:0]        m_arready,
    input  logic [NUM_M*ADDR_W-1:0] m_araddr,
    input  logic [NUM_M*3-1:0]      m_arprot,
    output logic [NUM_M-1:0]        m_rvalid,
    input  logic [NUM_M-1:0]        m_rready,
    output logic [NUM_M*DATA_W-1:0] m_rdata,
    output logic [NUM_M*2-1:0]      m_rresp,
    output logic                    s_arvalid,
    input  logic                    s_arready,
    output logic [ADDR_W-1:0]       s_araddr,
    output logic [2:0]              s_arprot,
    input  logic                    s_rvalid,
    output logic                    s_rready,
    input  logic [DATA_W-1:0]       s_rdata,
    input  logic [1:0]              s_rresp,
    output logic                    ar_hs,
    output logic                    r_hs
);

    logic [NUM_M-1:0] sel;

    generate
        for (genvar i = 0; i < NUM_M; i++) begin : g_m
            assign sel[i]                    = en && (owner == IDX_W'(i));
            assign m_arready[i]              = sel[i] && !ar_done && s_arready;
            assign m_rvalid[i]               = sel[i] && ar_done && s_rvalid;
            assign m_rdata[i*DATA_W +: DATA_W] = s_rdata;
            assign m_rresp[i*2 +: 2]         = s_rresp;
        end
    endgenerate

    always_comb begin
        s_araddr = '0;
        s_arprot = '0;
        for (int i = 0; i < NUM_M; i++) begin
            if (sel[i]) begin
                s_araddr = m_araddr[i*ADDR_W +: ADDR_W];
                s_arprot = m_arprot[i*3 +: 3];
            end
        end
    end

    assign s_arvalid = en && !ar_done && |(sel & m_arvalid);
    assign s_rready  = en && ar_done && |(sel & m_rready);

    assign ar_hs = s_arvalid && s_arready;
    assign r_hs  = s_rvalid && s_rready;

    // R9: read data and response go to exactly one master
    assert_r_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_hs |-> $onehot(m_rvalid & m_rready));

endmodule

// File: rtl/axil_rr_arbiter.sv
module axil_rr_arbiter
    import axil_arb_pkg::*;
#(
    parameter int NUM_M  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_M-1:0]           m_awvalid,
    output logic [NUM_M-1:0]           m_awready,
    input  logic [NUM_M*ADDR_W-1:0]    m_awaddr,
    input  logic [NUM_M*3-1:0]         m_awprot,
    input  logic [NUM_M-1:0]           m_wvalid,
    output logic [NUM_M-1:0]           m_wready,
    input  logic [NUM_M*DATA_W-1:0]    m_wdata,
    input  logic [NUM_M*DATA_W/8-1:0]  m_wstrb,
    output logic [NUM_M-1:0]           m_bvalid,
    input  logic [NUM_M-1:0]           m_bready,
    output logic [NUM_M*2-1:0]         m_bresp,
    input  logic [NUM_M-1:0]           m_arvalid,
    output logic [NUM_M-1:0]           m_arready,
    input  logic [NUM_M*ADDR_W-1:0]    m_araddr,
    input  logic [NUM_M*3-1:0]         m_arprot,
    output logic [NUM_M-1:0]           m_rvalid,
    input  logic [NUM_M-1:0]           m_rready,
    output logic [NUM_M*DATA_W-1:0]    m_rdata,
    output logic [NUM_M*2-1:0]         m_rresp,
    output logic                       s_awvalid,
    input  logic                       s_awready,
    output logic [ADDR_W-1:0]          s_awaddr,
    output logic [2:0]                 s_awprot,
    output logic                       s_wvalid,
    input  logic                       s_wready,
    output logic [DATA_W-1:0]          s_wdata,
    output logic [DATA_W/8-1:0]        s_wstrb,
    input  logic                       s_bvalid,
    output logic                       s_bready,
    input  logic [1:0]                 s_bresp,
    output logic                       s_arvalid,
    input  logic                       s_arready,
    output logic [ADDR_W-1:0]          s_araddr,
    output logic [2:0]                 s_arprot,
    input  logic                       s_rvalid,
    output logic                       s_rready,
    input  logic [DATA_W-1:0]          s_rdata,
    input  logic [1:0]                 s_rresp
);

    localparam int IDX_W = (NUM_M > 1) ? $clog2(NUM_M) : 1;

    typedef struct packed {
        arb_state_e       st;
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] ptr;
        logic             sticky;
        logic             aw_done;
        logic             w_done;
        logic             ar_done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_M-1:0] req;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] next_ptr;
    logic             wr_aw_hs, wr_w_hs, wr_b_hs;
    logic             rd_ar_hs, rd_r_hs;

    assign req      = m_awvalid | m_arvalid;
    assign next_ptr = (ctl_q.owner == IDX_W'(NUM_M - 1)) ? '0 : ctl_q.owner + 1'b1;

    axil_rr_pick #(
        .NUM_M (NUM_M),
        .IDX_W (IDX_W)
    ) u_pick (
        .req      (req),
        .ptr      (ctl_q.ptr),
        .keep_en  (ctl_q.sticky),
        .keep_idx (ctl_q.owner),
        .any      (pick_any),
        .idx      (pick_idx)
    );

    axil_wr_route #(
        .NUM_M  (NUM_M),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_q.st == ST_WR),
        .owner     (ctl_q.owner),
        .aw_done   (ctl_q.aw_done),
        .w_done    (ctl_q.w_done),
        .m_awvalid (m_awvalid),
        .m_awready (m_awready),
        .m_awaddr  (m_awaddr),
        .m_awprot  (m_awprot),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready),
        .m_wdata   (m_wdata),
        .m_wstrb   (m_wstrb),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready),
        .m_bresp   (m_bresp),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_awaddr  (s_awaddr),
        .s_awprot  (s_awprot),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_bresp   (s_bresp),
        .aw_hs     (wr_aw_hs),
        .w_hs      (wr_w_hs),
        .b_hs      (wr_b_hs)
    );

    axil_rd_route #(
        .NUM_M  (NUM_M),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_q.st == ST_RD),
        .owner     (ctl_q.owner),
        .ar_done   (ctl_q.ar_done),
        .m_arvalid (m_arvalid),
        .m_arready (m_arready),
        .m_araddr  (m_araddr),
        .m_arprot  (m_arprot),
        .m_rvalid  (m_rvalid),
        .m_rready  (m_rready),
        .m_rdata   (m_rdata),
        .m_rresp   (m_rresp),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_araddr  (s_araddr),
        .s_arprot  (s_arprot),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .ar_hs     (rd_ar_hs),
        .r_hs      (rd_r_hs)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.sticky = 1'b0;
                if (pick_any) begin
                    ctl_d.owner   = pick_idx;
                    // write request wins over a simultaneous read request
                    ctl_d.st      = m_awvalid[pick_idx] ? ST_WR : ST_RD;
                    ctl_d.aw_done = 1'b0;
                    ctl_d.w_done  = 1'b0;
                    ctl_d.ar_done = 1'b0;
                end
            end
            ST_WR: begin
                if (wr_aw_hs) ctl_d.aw_done = 1'b1;
                if (wr_w_hs)  ctl_d.w_done  = 1'b1;
                if (wr_b_hs) begin
                    ctl_d.st     = ST_IDLE;
                    ctl_d.ptr    = next_ptr;
                    ctl_d.sticky = 1'b1;
                end
            end
            ST_RD: begin
                if (rd_ar_hs) ctl_d.ar_done = 1'b1;
                if (rd_r_hs) begin
                    ctl_d.st     = ST_IDLE;
                    ctl_d.ptr    = next_ptr;
                    ctl_d.sticky = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, owner: '0, ptr: '0, sticky: 1'b0,
                       aw_done: 1'b0, w_done: 1'b0, ar_done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // ---------------- checks ----------------
    logic [NUM_M-1:0] vis;
    logic [1:0]       outst_q;
    logic             addr_hs, resp_hs;

    assign vis     = m_awready | m_wready | m_bvalid | m_arready | m_rvalid;
    assign addr_hs = wr_aw_hs || rd_ar_hs;
    assign resp_hs = wr_b_hs || rd_r_hs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= '0;
        end else if (addr_hs && !resp_hs) begin
            outst_q <= outst_q + 2'd1;
        end else if (resp_hs && !addr_hs && outst_q != 2'd0) begin
            outst_q <= outst_q - 2'd1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) |-> (vis == '0) && !s_awvalid && !s_wvalid && !s_arvalid);

    assert_keep_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && ctl_q.sticky && req[ctl_q.owner])
        |=> (ctl_q.st != ST_IDLE) && (ctl_q.owner == $past(ctl_q.owner)));

    assert_read_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && pick_any && !m_awvalid[pick_idx]) |=> (ctl_q.st == ST_RD));

    assert_write_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && pick_any && m_awvalid[pick_idx]) |=> (ctl_q.st == ST_WR));

    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vis));

    assert_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q <= 2'd1);

    assert_no_addr_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (outst_q == 2'd1) |-> !addr_hs);

endmodule

// File: tb/axil_rr_arbiter_tb.sv
module axil_rr_arbiter_tb;

    localparam int N  = 3;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]    m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
    logic [N-1:0]    m_arvalid, m_arready, m_rvalid, m_rready;
    logic [N*AW-1:0] m_awaddr, m_araddr;
    logic [N*3-1:0]  m_awprot, m_arprot;
    logic [N*DW-1:0] m_wdata, m_rdata;
    logic [N*SW-1:0] m_wstrb;
    logic [N*2-1:0]  m_bresp, m_rresp;
    logic            s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready;
    logic [AW-1:0]   s_awaddr, s_araddr;
    logic [2:0]      s_awprot, s_arprot;
    logic [DW-1:0]   s_wdata;
    logic [SW-1:0]   s_wstrb;
    logic            s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]      s_bresp, s_rresp;
    logic [DW-1:0]   s_rdata;

    // master-side drive, one entry per master
    logic          awv_a[N], wv_a[N], bry_a[N], arv_a[N], rry_a[N];
    logic [AW-1:0] awa_a[N], ara_a[N];
    logic [2:0]    awp_a[N], arp_a[N];
    logic [DW-1:0] wd_a[N];
    logic [SW-1:0] ws_a[N];

    for (genvar i = 0; i < N; i++) begin : g_drv
        assign m_awvalid[i]        = awv_a[i];
        assign m_wvalid[i]         = wv_a[i];
        assign m_bready[i]         = bry_a[i];
        assign m_arvalid[i]        = arv_a[i];
        assign m_rready[i]         = rry_a[i];
        assign m_awaddr[i*AW +: AW] = awa_a[i];
        assign m_araddr[i*AW +: AW] = ara_a[i];
        assign m_awprot[i*3 +: 3]  = awp_a[i];
        assign m_arprot[i*3 +: 3]  = arp_a[i];
        assign m_wdata[i*DW +: DW] = wd_a[i];
        assign m_wstrb[i*SW +: SW] = ws_a[i];
    end

    axil_rr_arbiter #(.NUM_M(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awprot(m_awprot),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr), .m_arprot(m_arprot),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awprot(s_awprot),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arprot(s_arprot),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp)
    );

    int n_chk = 0;
    int n_fail = 0;
    int mon_r7 = 0;
    int mon_r8 = 0;
    int n_issued = 0;

    // ---------------- reference functions ----------------
    function automatic logic [2:0] prot_f(logic [31:0] a);
        return a[10:8];
    endfunction
    function automatic logic [31:0] wdat_f(logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction
    function automatic logic [3:0] strb_f(logic [31:0] a);
        return a[5:2];
    endfunction
    function automatic logic [1:0] bresp_f(logic [31:0] a);
        return (a[3:2] == 2'd3) ? 2'b10 : 2'b00;
    endfunction
    function automatic logic [31:0] rdat_f(logic [31:0] a);
        return a * 32'h9E37_79B1 + 32'd1;
    endfunction
    function automatic logic [1:0] rresp_f(logic [31:0] a);
        return (a[4:2] == 3'd6) ? 2'b11 : 2'b00;
    endfunction
    function automatic logic [31:0] waddr_f(int m, int j);
        return 32'(m * 256 + j * 4);
    endfunction
    function automatic logic [31:0] raddr_f(int m, int j);
        return 32'(m * 256 + 128 + j * 4);
    endfunction
    // back-to-back: each master's 4 writes then 4 reads, masters in index order
    function automatic logic [32:0] exp_block(int k);
        int m = k / 8;
        int j = k % 8;
        return (j < 4) ? {1'b1, waddr_f(m, j)} : {1'b0, raddr_f(m, j - 4)};
    endfunction
    // paused traffic: masters rotate after every transaction
    function automatic logic [32:0] exp_rot(int k);
        int t = k / 3;
        int m = k % 3;
        return (t < 4) ? {1'b1, waddr_f(m, t)} : {1'b0, raddr_f(m, t - 4)};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ---------------- slave model and log ----------------
    logic [32:0] log_e[256];
    int          n_log = 0;
    bit          rnd_slave = 0;

    logic          hold_aw = 0, hold_w = 0, hold_ar = 0, busy = 0;
    logic [31:0]   aw_c, ar_c, wd_c;
    logic [2:0]    awp_c, arp_c;
    logic [3:0]    ws_c;

    initial begin
        s_awready = 0; s_wready = 0; s_arready = 0;
        s_bvalid = 0; s_bresp = 0; s_rvalid = 0; s_rdata = 0; s_rresp = 0;
        forever begin
            bit aw_h, w_h, b_h, ar_h, r_h;
            @(negedge clk);
            aw_h = s_awvalid && s_awready;
            w_h  = s_wvalid && s_wready;
            b_h  = s_bvalid && s_bready;
            ar_h = s_arvalid && s_arready;
            r_h  = s_rvalid && s_rready;
            if ($countones(m_awready | m_wready | m_bvalid | m_arready | m_rvalid) > 1) mon_r7++;
            if ((aw_h || ar_h) && busy) mon_r8++;
            if (aw_h || ar_h) begin
                busy = 1;
                if (n_log < 256) log_e[n_log] = aw_h ? {1'b1, s_awaddr} : {1'b0, s_araddr};
                n_log++;
            end
            if (aw_h) begin aw_c = s_awaddr; awp_c = s_awprot; end
            if (w_h)  begin wd_c = s_wdata; ws_c = s_wstrb; end
            if (ar_h) begin ar_c = s_araddr; arp_c = s_arprot; end
            if (b_h || r_h) busy = 0;
            @(posedge clk);
            #1;
            if (aw_h) hold_aw = 1;
            if (w_h)  hold_w = 1;
            if (ar_h) hold_ar = 1;
            if (b_h) begin s_bvalid = 0; hold_aw = 0; hold_w = 0; end
            if (r_h) begin s_rvalid = 0; hold_ar = 0; end
            if (hold_aw && hold_w && !s_bvalid && (!rnd_slave || $urandom % 2 == 0)) begin
                chk(wd_c == wdat_f(aw_c) && ws_c == strb_f(aw_c) && awp_c == prot_f(aw_c),
                    "R9", "write fields at slave", {wd_c, 25'd0, awp_c, ws_c},
                    {wdat_f(aw_c), 25'd0, prot_f(aw_c), strb_f(aw_c)});
                s_bvalid = 1;
                s_bresp  = bresp_f(aw_c);
            end
            if (hold_ar && !s_rvalid && (!rnd_slave || $urandom % 2 == 0)) begin
                chk(arp_c == prot_f(ar_c), "R9", "read prot at slave", 64'(arp_c), 64'(prot_f(ar_c)));
                s_rvalid = 1;
                s_rdata  = rdat_f(ar_c);
                s_rresp  = rresp_f(ar_c);
            end
            s_awready = !hold_aw && (!rnd_slave || $urandom % 3 != 0);
            s_wready  = !hold_w  && (!rnd_slave || $urandom % 3 != 0);
            s_arready = !hold_ar && (!rnd_slave || $urandom % 3 != 0);
        end
    end

    // ---------------- master tasks ----------------
    task automatic mwrite(input int m, input logic [31:0] a);
        bit ahs, whs, done;
        logic [1:0] resp;
        awa_a[m] = a; awp_a[m] = prot_f(a); wd_a[m] = wdat_f(a); ws_a[m] = strb_f(a);
        awv_a[m] = 1; wv_a[m] = 1; bry_a[m] = 1;
        done = 0; resp = 0;
        n_issued++;
        while (!done) begin
            @(negedge clk);
            ahs = awv_a[m] && m_awready[m];
            whs = wv_a[m] && m_wready[m];
            if (m_bvalid[m] && bry_a[m]) begin resp = m_bresp[m*2 +: 2]; done = 1; end
            @(posedge clk);
            #1;
            if (ahs) awv_a[m] = 0;
            if (whs) wv_a[m] = 0;
        end
        bry_a[m] = 0;
        chk(resp == bresp_f(a), "R9", $sformatf("bresp m%0d", m), 64'(resp), 64'(bresp_f(a)));
    endtask

    task automatic mread(input int m, input logic [31:0] a);
        bit ahs, done;
        logic [1:0]  resp;
        logic [31:0] dat;
        ara_a[m] = a; arp_a[m] = prot_f(a);
        arv_a[m] = 1; rry_a[m] = 1;
        done = 0; resp = 0; dat = 0;
        n_issued++;
        while (!done) begin
            @(negedge clk);
            ahs = arv_a[m] && m_arready[m];
            if (m_rvalid[m] && rry_a[m]) begin
                resp = m_rresp[m*2 +: 2]; dat = m_rdata[m*DW +: DW]; done = 1;
            end
            @(posedge clk);
            #1;
            if (ahs) arv_a[m] = 0;
        end
        rry_a[m] = 0;
        chk(resp == rresp_f(a) && dat == rdat_f(a), "R9", $sformatf("read return m%0d", m),
            {30'd0, resp, dat}, {30'd0, rresp_f(a), rdat_f(a)});
    endtask

    task automatic idle(input int c);
        repeat (c) begin @(posedge clk); #1; end
    endtask

    task automatic master_seq(input int m, input int gap);
        for (int j = 0; j < 4; j++) begin mwrite(m, waddr_f(m, j)); idle(gap); end
        for (int j = 0; j < 4; j++) begin mread(m, raddr_f(m, j)); idle(gap); end
    endtask

    task automatic check_order(input string tag, input bit rot, input int total);
        int bad = -1;
        for (int k = 0; k < total; k++) begin
            logic [32:0] e = rot ? exp_rot(k) : exp_block(k);
            if (bad < 0 && log_e[k] != e) bad = k;
        end
        if (bad < 0) chk(n_log == total, tag, "slave transaction count", 64'(n_log), 64'(total));
        else chk(0, tag, $sformatf("slave order at %0d", bad), 64'(log_e[bad]),
                 64'(rot ? exp_rot(bad) : exp_block(bad)));
    endtask

    task automatic random_master(input int m);
        for (int it = 0; it < 20; it++) begin
            int kind = int'($urandom % 3);
            logic [31:0] a = 32'(m * 256) + (($urandom % 64) * 4);
            if (kind == 0) mwrite(m, a);
            else if (kind == 1) mread(m, a);
            else fork mwrite(m, a); mread(m, a ^ 32'h4); join
            idle(int'($urandom % 3));
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            awv_a[i] = 0; wv_a[i] = 0; bry_a[i] = 0; arv_a[i] = 0; rry_a[i] = 0;
            awa_a[i] = 0; ara_a[i] = 0; awp_a[i] = 0; arp_a[i] = 0; wd_a[i] = 0; ws_a[i] = 0;
        end
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        idle(2);

        // R1: nothing granted after reset, slave side quiet
        @(negedge clk);
        chk((m_awready | m_wready | m_bvalid | m_arready | m_rvalid) == '0, "R1",
            "master-side outputs after reset",
            64'(m_awready | m_wready | m_bvalid | m_arready | m_rvalid), 64'd0);
        chk(!s_awvalid && !s_wvalid && !s_arvalid, "R1", "slave valids after reset",
            64'({s_awvalid, s_wvalid, s_arvalid}), 64'd0);
        @(posedge clk); #1;

        // R3 R5 R1: back-to-back traffic keeps the grant; master 0 first from reset
        n_log = 0;
        fork master_seq(0, 0); master_seq(1, 0); master_seq(2, 0); join
        idle(4);
        check_order("R3 R5 R1", 1'b0, 24);

        // R4 R5: one idle cycle between transactions rotates the grant
        n_log = 0;
        fork master_seq(0, 1); master_seq(1, 1); master_seq(2, 1); join
        idle(4);
        check_order("R4 R5", 1'b1, 24);

        // R2: pointer left at master 2 after master 1 finishes; search wraps
        n_log = 0;
        mwrite(1, waddr_f(1, 5));
        idle(3);
        fork mwrite(0, waddr_f(0, 6)); mwrite(2, waddr_f(2, 6)); join
        idle(3);
        chk(n_log == 3 && log_e[1] == {1'b1, waddr_f(2, 6)} && log_e[2] == {1'b1, waddr_f(0, 6)},
            "R2", "pointer wrap order", 64'(log_e[1]), 64'({1'b1, waddr_f(2, 6)}));

        // R6: same-cycle write and read from one master, write first
        n_log = 0;
        fork mwrite(1, waddr_f(1, 7)); mread(1, raddr_f(1, 7)); join
        idle(3);
        chk(n_log == 2 && log_e[0] == {1'b1, waddr_f(1, 7)} && log_e[1] == {1'b0, raddr_f(1, 7)},
            "R6", "write served before read", 64'(log_e[0]), 64'({1'b1, waddr_f(1, 7)}));

        // random traffic against a stalling slave
        n_log = 0;
        n_issued = 0;
        rnd_slave = 1;
        fork random_master(0); random_master(1); random_master(2); join
        idle(6);
        chk(n_log == n_issued, "R2", "all random requests served", 64'(n_log), 64'(n_issued));

        chk(mon_r7 == 0, "R7", "cycles with more than one master selected", 64'(mon_r7), 64'd0);
        chk(mon_r8 == 0, "R8", "address handshakes while busy", 64'(mon_r8), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule